// File: doc/BRIEF.md
# Two-Wire Serial Register Slave

This block is a slave on a two-wire serial bus (clock line plus open-drain data line). It gives an external master read and write access to a bank of sixteen 8-bit registers. Both lines are synchronized into the system clock domain. Start and stop conditions are recognised there, and the block then frames bits into bytes. It answers only to one 7-bit device address, and one bit of that address comes from a strap input. On the data line the block only ever pulls low, through `sda_oe_o`; the pad releases the line when that output is 0.

A write transfer is the device address byte with the direction flag at 0, then a register address byte, then data bytes. The register address byte sets the register index and the access mode. The mode applies to the rest of the transfer and to later reads.
- In alternating mode every data byte needs a fresh register address byte in front of it.
- In auto-increment mode the index steps by one after each data byte.

A read transfer is the device address byte with the direction flag at 1. It returns data from the stored index, most significant bit first, until the master answers a byte with a not-acknowledge. The system clock must run at least 8 times faster than the serial clock.

The controller is one state machine with these states:
- `ST_IDLE`: waiting for a start.
- `ST_DEV`: receiving the device address byte.
- `ST_DEV_ACK`: acknowledging the device address.
- `ST_REG`: receiving the register address byte.
- `ST_REG_ACK`: acknowledging the register address.
- `ST_WR`: receiving a write data byte.
- `ST_WR_ACK`: acknowledging a write data byte.
- `ST_RD`: sending a read data byte.
- `ST_RD_ACK`: sampling the master's acknowledge.
- `ST_IGNORE`: deaf until the next start.

Its transitions are:
- Any state goes to `ST_DEV` on a start and to `ST_IDLE` on a stop.
- `ST_DEV` goes to `ST_DEV_ACK` on an address match, or to `ST_IGNORE` on a mismatch.
- `ST_DEV_ACK` goes to `ST_RD` when the direction flag is 1, or to `ST_REG` when it is 0.
- `ST_REG` → `ST_REG_ACK` → `ST_WR`.
- `ST_WR` → `ST_WR_ACK`. `ST_WR_ACK` then goes back to `ST_WR` in auto-increment mode, or to `ST_REG` in alternating mode.
- `ST_RD` → `ST_RD_ACK`. `ST_RD_ACK` then goes back to `ST_RD` on an acknowledge, or to `ST_IGNORE` on a not-acknowledge.
- Each byte-state transition happens on the serial clock falling edge that ends the byte or the ninth clock.

Top module: `regbus_slave`

## Requirements
- R1: A stop (data rising while clock high) returns the block to idle. Bytes clocked after a stop and before the next start are not acknowledged, and the data line stays released.
- R2: The device address byte, most significant bit first, is 1,1,1,0,1, then the inverse of `strap_i`, then `strap_i`, then the direction flag (0 = write, 1 = read). With strap 1 that gives 0xEA for write and 0xEB for read; with strap 0 it gives 0xEC and 0xED. On a match the block pulls the data line low throughout the ninth clock.
- R3: On a device address mismatch the block gives no acknowledge. Later bytes until the next start are neither acknowledged nor written.
- R4: In the register address byte, bits 3..0 are the register index and bit 6 selects the mode (1 = auto-increment, 0 = alternating). Bits 7, 5 and 4 are ignored. Every register address byte is acknowledged.
- R5: In alternating write mode each data byte is written to the index of the register address byte just before it, and the next byte is again taken as a register address byte. Every data byte is acknowledged.
- R6: In auto-increment write mode consecutive data bytes go to consecutive indices, and index 15 wraps to 0.
- R7: A read returns the register at the stored index, most significant bit first. The block changes the data line only while the clock is low. In alternating mode repeated read bytes return the same register.
- R8: In auto-increment read mode each byte the master acknowledges is followed by the next index, wrapping 15 to 0.
- R9: A not-acknowledge from the master after a read byte makes the block release the data line until the next start.
- R10: A start in the middle of a byte discards the partial byte and begins a new device address byte.
- R11: After reset all registers read 0 and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| strap_i | input | 1 | Strap pin that sets one device address bit |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench sweeps all 128 device addresses under both strap values. A wrong match pattern, such as swapped strap bits, would acknowledge the wrong byte. It fills all sixteen registers in alternating mode, with the ignored address bits set, and reads each one twice. A design that decoded bits 7, 5 or 4 of the register address, or that advanced the index in alternating mode, would land data in the wrong place or repeat the wrong value. It writes and reads in auto-increment mode across the 15→0 boundary, where a missing wrap would lose a byte. It also covers four more cases:
- A mismatched address followed by writes, which would change a register if the block did not stay deaf.
- Clocks after a stop, which would be acknowledged if the block did not return to idle.
- A read of a zero byte ended with a not-acknowledge, where a slave that kept driving would hold the line low.
- A start in the middle of a byte, which a design that kept its old bit count would mis-frame.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_IGNORE
    } bus_state_t;

    // Fixed upper bits of the device address, followed by ~strap, strap, rw
    localparam logic [4:0] DEV_PREFIX = 5'b11101;

endpackage

// File: rtl/regbus_line_sync.sv
module regbus_line_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= {(STAGES+1){RESET_VAL}};
        end else begin
            pipe <= {pipe[STAGES-1:0], line_i};
        end
    end

    // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
    assign level_o = pipe[STAGES-1];
    assign rise_o  =  pipe[STAGES-1] & ~pipe[STAGES];
    assign fall_o  = ~pipe[STAGES-1] &  pipe[STAGES];

endmodule

// File: rtl/regbus_regfile.sv
module regbus_regfile #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int NUM_REGS = 1 << ADDR_W;

    logic [DATA_W-1:0] regs [NUM_REGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs[i] <= '0;
            end
        end else if (wr_en) begin
            regs[idx] <= wr_data;
        end
    end

    assign rd_data = regs[idx];

endmodule

// File: rtl/regbus_slave.sv
module regbus_slave #(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int MODE_BIT    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic strap_i,
    output logic sda_oe_o
);
    import regbus_pkg::*;

    localparam int               CNT_W    = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DATA_W);

    // Synchronized lines and edge events
    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic start_p, stop_p;

    regbus_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_scl_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (scl_i),
        .level_o (scl_lvl),
        .rise_o  (scl_rise),
        .fall_o  (scl_fall)
    );

    regbus_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sda_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (sda_i),
        .level_o (sda_lvl),
        .rise_o  (sda_rise),
        .fall_o  (sda_fall)
    );

    // A data edge while the clock is high is only ever a framing condition
    assign start_p = sda_fall & scl_lvl;
    assign stop_p  = sda_rise & scl_lvl;

    // Controller state and datapath
    bus_state_t        state, nxt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic [ADDR_W-1:0] reg_idx;
    logic              auto_q;
    logic              rw_q;
    logic              mnack_q;
    logic              byte_done;
    logic              addr_hit;
    logic              rx_state;
    logic              wr_en;
    logic [DATA_W-1:0] rd_data;

    assign byte_done = (bit_cnt == BIT_LAST);
    assign addr_hit  = (rx_sh[7:3] == DEV_PREFIX) &&
                       (rx_sh[2] == ~strap_i) && (rx_sh[1] == strap_i);
    assign rx_state  = (state == ST_DEV) || (state == ST_REG) ||
                       (state == ST_WR)  || (state == ST_RD);
    assign wr_en     = (state == ST_WR) && scl_fall && byte_done && !start_p && !stop_p;

    regbus_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .idx     (reg_idx),
        .wr_data (rx_sh),
        .rd_data (rd_data)
    );

    // Next-state logic
    always_comb begin
        nxt = state;
        if (start_p) begin
            nxt = ST_DEV;
        end else if (stop_p) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    nxt = ST_IDLE;
                ST_IGNORE:  nxt = ST_IGNORE;
                ST_DEV:     if (scl_fall && byte_done) nxt = addr_hit ? ST_DEV_ACK : ST_IGNORE;
                ST_DEV_ACK: if (scl_fall) nxt = rw_q ? ST_RD : ST_REG;
                ST_REG:     if (scl_fall && byte_done) nxt = ST_REG_ACK;
                ST_REG_ACK: if (scl_fall) nxt = ST_WR;
                ST_WR:      if (scl_fall && byte_done) nxt = ST_WR_ACK;
                ST_WR_ACK:  if (scl_fall) nxt = auto_q ? ST_WR : ST_REG;
                ST_RD:      if (scl_fall && byte_done) nxt = ST_RD_ACK;
                ST_RD_ACK:  if (scl_fall) nxt = mnack_q ? ST_IGNORE : ST_RD;
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Datapath: bit counting, shifting, index and mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            reg_idx <= '0;
            auto_q  <= 1'b0;
            rw_q    <= 1'b0;
            mnack_q <= 1'b1;
        end else if (start_p || stop_p) begin
            bit_cnt <= '0;
        end else begin
            if (rx_state && scl_rise) begin
                bit_cnt <= bit_cnt + CNT_W'(1);
                if (state != ST_RD) begin
                    rx_sh <= {rx_sh[DATA_W-2:0], sda_lvl};
                end
            end
            if (rx_state && scl_fall && byte_done) begin
                bit_cnt <= '0;
            end
            unique case (state)
                ST_DEV: begin
                    if (scl_fall && byte_done) rw_q <= rx_sh[0];
                end
                ST_DEV_ACK: begin
                    if (scl_fall) tx_sh <= rd_data;
                end
                ST_REG: begin
                    if (scl_fall && byte_done) begin
                        reg_idx <= rx_sh[ADDR_W-1:0];
                        auto_q  <= rx_sh[MODE_BIT];
                    end
                end
                ST_WR: begin
                    if (scl_fall && byte_done && auto_q) reg_idx <= reg_idx + ADDR_W'(1);
                end
                ST_RD: begin
                    if (scl_fall) begin
                        if (byte_done) begin
                            if (auto_q) reg_idx <= reg_idx + ADDR_W'(1);
                        end else begin
                            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) mnack_q <= sda_lvl;
                    if (scl_fall) tx_sh <= rd_data;
                end
                default: ;
            endcase
        end
    end

    // Output decode: the block only ever pulls the line low
    always_comb begin
        unique case (state)
            ST_DEV_ACK, ST_REG_ACK, ST_WR_ACK: sda_oe_o = 1'b1;
            ST_RD:                             sda_oe_o = ~tx_sh[DATA_W-1];
            default:                           sda_oe_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/regbus_slave_chk.sv
module regbus_slave_chk
    import regbus_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic       sda_oe_o,
    input bus_state_t state,
    input logic [3:0] bit_cnt,
    input logic       start_p,
    input logic       stop_p
);

    assert_stop_to_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p && !start_p |=> state == ST_IDLE);

    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !sda_oe_o);

    assert_ignore_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IGNORE |-> !sda_oe_o);

    assert_line_moves_clock_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_lvl);

    assert_start_restarts_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> state == ST_DEV && bit_cnt == 4'd0);

    assert_bit_count_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= 4'd8);

endmodule

bind regbus_slave regbus_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (scl_lvl),
    .sda_oe_o (sda_oe_o),
    .state    (state),
    .bit_cnt  (bit_cnt),
    .start_p  (start_p),
    .stop_p   (stop_p)
);

// File: tb/regbus_slave_tb.sv
`timescale 1ns/1ps
module regbus_slave_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic strap = 1'b1;
    logic sda_oe;
    logic sda_line;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    regbus_slave u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .strap_i  (strap),
        .sda_oe_o (sda_oe)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic qw();
        repeat (5) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b0; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b1; qw();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; qw();
        scl_m = 1'b1; qw(); qw();
        scl_m = 1'b0; qw();
    endtask

    // returns 1 when the slave acknowledged
    task automatic wbyte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        acked = ~sda_line;
        qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic rbyte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            qw();
            scl_m = 1'b1; qw();
            b = {b[6:0], sda_line};
            qw();
            scl_m = 1'b0;
        end
        qw();
        sda_m = nack; qw();
        scl_m = 1'b1; qw(); qw();
        scl_m = 1'b0; qw();
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] fill_val(input int i);
        return 8'((i * 37 + 11) & 8'hFF);
    endfunction

    // strap=1 addresses: 0xEA write, 0xEB read
    task automatic read_reg(input logic [7:0] rab, output logic [7:0] v);
        logic a;
        bus_start(); wbyte(8'hEA, a); wbyte(rab, a);
        bus_start(); wbyte(8'hEB, a);
        rbyte(1'b1, v);
        bus_stop();
    endtask

    initial begin
        logic a;
        logic [7:0] v, v2;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        qw();
        check("R11 line released after reset", int'(sda_oe), 0);

        // R11: every register reads zero after reset
        for (int i = 0; i < 16; i++) begin
            read_reg(8'(i), v);
            check("R11 reset register value", int'(v), 0);
        end

        // R2/R3: sweep every 7-bit address under both strap values
        for (int s = 0; s < 2; s++) begin
            strap = 1'(s);
            for (int ad = 0; ad < 128; ad++) begin
                bus_start();
                wbyte(8'(ad << 1), a);
                check("R2 address match and acknowledge", int'(a),
                      int'(ad == {5'b11101, ~1'(s), 1'(s)}));
                bus_stop();
            end
        end
        strap = 1'b1;

        // R4/R5: alternating write with ignored bits 7,5,4 set
        bus_start();
        wbyte(8'hEA, a);
        check("R2 write address acknowledged", int'(a), 1);
        for (int i = 0; i < 16; i++) begin
            wbyte(8'(i) | 8'hB0, a);
            check("R4 register address acknowledged", int'(a), 1);
            wbyte(fill_val(i), a);
            check("R5 alternating data acknowledged", int'(a), 1);
        end
        bus_stop();

        // R7: alternating read, two bytes per register give the same value
        for (int i = 0; i < 16; i++) begin
            bus_start(); wbyte(8'hEA, a); wbyte(8'(i), a);
            bus_start(); wbyte(8'hEB, a);
            check("R2 read address acknowledged", int'(a), 1);
            rbyte(1'b0, v);
            rbyte(1'b1, v2);
            bus_stop();
            check("R5 R7 alternating read first byte", int'(v), int'(fill_val(i)));
            check("R7 alternating read repeats register", int'(v2), int'(fill_val(i)));
        end

        // R6: auto-increment write from index 14 wraps to 0 and 1
        bus_start(); wbyte(8'hEA, a); wbyte(8'hFE, a);
        for (int k = 0; k < 4; k++) begin
            wbyte(8'(8'hA0 + k), a);
            check("R6 auto-increment data acknowledged", int'(a), 1);
        end
        bus_stop();
        for (int k = 0; k < 4; k++) begin
            read_reg(8'((14 + k) % 16), v);
            check("R6 auto-increment write wrap", int'(v), int'(8'hA0 + k));
        end
        read_reg(8'd2, v);
        check("R6 register past the burst untouched", int'(v), int'(fill_val(2)));

        // R8: auto-increment read from 13 across the wrap
        bus_start(); wbyte(8'hEA, a); wbyte(8'h4D, a);
        bus_start(); wbyte(8'hEB, a);
        for (int k = 0; k < 5; k++) begin
            rbyte(k == 4, v);
            check("R8 auto-increment read sequence", int'(v),
                  (k == 0) ? int'(fill_val(13)) : int'(8'hA0 + k - 1));
        end
        bus_stop();

        // R3: mismatched address, following bytes ignored
        bus_start();
        wbyte(8'hEC, a);
        check("R3 mismatch not acknowledged", int'(a), 0);
        wbyte(8'h03, a);
        check("R3 byte after mismatch not acknowledged", int'(a), 0);
        wbyte(8'h55, a);
        check("R3 data after mismatch not acknowledged", int'(a), 0);
        bus_stop();
        read_reg(8'd3, v);
        check("R3 register unchanged after mismatch", int'(v), int'(fill_val(3)));

        // R1: clocks after a stop and with no start are ignored
        wbyte(8'hEA, a);
        check("R1 no acknowledge while idle", int'(a), 0);
        check("R1 line released while idle", int'(sda_oe), 0);
        bus_stop();

        // R9: zero byte read, master not-acknowledge releases the line
        bus_start(); wbyte(8'hEA, a); wbyte(8'h06, a); wbyte(8'h00, a); bus_stop();
        bus_start(); wbyte(8'hEA, a); wbyte(8'h46, a);
        bus_start(); wbyte(8'hEB, a);
        rbyte(1'b1, v);
        check("R9 zero byte read", int'(v), 0);
        for (int i = 0; i < 9; i++) begin
            qw(); scl_m = 1'b1; qw();
            check("R9 line released after not-acknowledge", int'(sda_line), 1);
            qw(); scl_m = 1'b0;
        end
        qw();
        bus_stop();

        // R10: start in the middle of a byte restarts framing
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_start();
        wbyte(8'hEA, a);
        check("R10 address after restart acknowledged", int'(a), 1);
        wbyte(8'h07, a); wbyte(8'h5A, a);
        bus_stop();
        read_reg(8'd7, v);
        check("R10 write after restart landed", int'(v), 8'h5A);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule